// File: doc/BRIEF.md
# Multi-Mode PWM Channel Generator

This block drives one pulse-width-modulated output from a counter that advances once per prescaled tick. Software-style write strobes load a period value and a compare (duty) value into holding registers; the channel copies them into its working registers only when a period completes, so a change never produces a truncated or stretched pulse. The counter either ramps upward and wraps (edge-aligned) or climbs and then descends (center-aligned), and the duty compare sets how many ticks around count zero the output is active. A polarity input chooses whether the active level is high or low.

Edges of the output can raise a sticky interrupt flag, a one-cycle DMA request and a hardware trigger pulse of programmable width, each with its own enable and a shared edge-type selector. A group-sync input holds an enabled channel at count zero until a shared start strobe arrives, so several channels can begin in lock-step. The current count and the output level are visible on ports.

The channel is controlled by a four-state machine. ST_OFF (disabled) moves to ST_ARMED once enable is high. ST_ARMED moves to ST_UP, clearing the count and loading the holding registers, when group sync is off or the start strobe is seen. ST_UP moves to ST_DOWN in center mode when the count reaches the period; ST_DOWN returns to ST_UP, loading the holding registers, when the count reaches zero. In edge mode ST_UP wraps to zero and loads at the period end. Any state returns to ST_OFF when enable is low.

Top module: `pwm_channel`

## Requirements
- R1: After reset cnt_value is 0, irq, dma_req and trig_out are 0, and pwm_out sits at the idle level (low when pol_high is 1).
- R2: While running, the count moves once every clk_div+1 clock cycles.
- R3: With center_mode 0 and period P, the count runs 0..P-1 and wraps to 0; the output is active while count < duty.
- R4: With center_mode 1 and period P, the count runs 0,1..P then P-1..1 and back to 0, one cycle lasting 2P ticks; the output is active while count < duty.
- R5: A duty of 0 keeps the output inactive for the whole period; a duty at or above the period keeps it active for the whole period.
- R6: pol_high 1 makes the active level high and the idle level low; pol_high 0 inverts both.
- R7: Period and duty writes land in holding registers and reach the output only when the count returns to 0 at the end of a period (or at start).
- R8: edge_sel bit 0 selects rising and bit 1 falling output edges; a selected edge with irq_en sets irq one cycle later; irq stays set until eoi; when an edge and eoi coincide, irq stays set.
- R9: A selected edge with dma_en raises dma_req for exactly the next cycle, independently of irq_en.
- R10: A selected edge with trig_en starts a trig_out pulse on the next cycle lasting trig_width cycles (1 cycle when trig_width is 0); a new edge restarts it.
- R11: With group_sync 1, an enabled channel holds count 0 and the idle level until sync_start is seen, then starts counting.
- R12: Dropping enable returns pwm_out to the idle level and clears the count on the next clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Channel run enable |
| group_sync | input | 1 | Wait for sync_start before counting |
| sync_start | input | 1 | Shared group start strobe |
| center_mode | input | 1 | 1 = center-aligned, 0 = edge-aligned |
| pol_high | input | 1 | 1 = active-high output |
| edge_sel | input | 2 | Bit 0 rising, bit 1 falling edge select |
| irq_en | input | 1 | Interrupt enable |
| dma_en | input | 1 | DMA request enable |
| trig_en | input | 1 | Hardware trigger enable |
| trig_width | input | TW (8) | Trigger pulse width in clock cycles |
| clk_div | input | DW (8) | Tick divider; tick every clk_div+1 cycles |
| prd_wr | input | 1 | Period holding-register write strobe |
| prd_data | input | CW (16) | Period value in ticks |
| duty_wr | input | 1 | Duty holding-register write strobe |
| duty_data | input | CW (16) | Duty compare value in ticks |
| eoi | input | 1 | End-of-interrupt, clears irq |
| pwm_out | output | 1 | PWM output pin level |
| cnt_value | output | CW (16) | Current count |
| irq | output | 1 | Sticky interrupt status |
| dma_req | output | 1 | One-cycle DMA request |
| trig_out | output | 1 | Hardware trigger pulse |

## Verification
The interrupt flag can be set by an output edge in the same cycle that eoi tries to clear it. The bench holds eoi high across a stretch in which the output toggles several times, so edges and clears are certain to collide, and the reference model expects the flag to remain set after each such cycle and to fall only on a clean eoi. A second collision, a holding-register write in the very cycle the period ends, is provoked by writing while the model is near the wrap and is judged by the model loading the old value.

// File: rtl/pwm_pkg.sv
package pwm_pkg;
    typedef enum logic [1:0] {
        ST_OFF   = 2'd0,
        ST_ARMED = 2'd1,
        ST_UP    = 2'd2,
        ST_DOWN  = 2'd3
    } pwm_state_e;

    localparam int SEL_RISE = 0;
    localparam int SEL_FALL = 1;
endpackage

// File: rtl/pwm_prescaler.sv
module pwm_prescaler #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run,
    input  logic [DW-1:0] clk_div,
    output logic          tick
);
    logic [DW-1:0] div_q;

    assign tick = run && (div_q == clk_div);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            div_q <= '0;
        end else if (!run || tick) begin
            div_q <= '0;
        end else begin
            div_q <= div_q + 1'b1;
        end
    end
endmodule

// File: rtl/pwm_core.sv
module pwm_core
    import pwm_pkg::*;
#(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          enable,
    input  logic          group_sync,
    input  logic          sync_start,
    input  logic          center_mode,
    input  logic          tick,
    input  logic          prd_wr,
    input  logic [CW-1:0] prd_data,
    input  logic          duty_wr,
    input  logic [CW-1:0] duty_data,
    output logic [CW-1:0] cnt,
    output logic          running,
    output logic          active
);
    pwm_state_e    st_q, st_nx;
    logic [CW-1:0] cnt_nx;
    logic [CW-1:0] prd_sh, duty_sh, prd_act, duty_act;
    logic          boundary;
    logic [CW:0]   cnt_inc;

    assign cnt_inc = {1'b0, cnt} + 1'b1;

    always_comb begin
        st_nx    = st_q;
        cnt_nx   = cnt;
        boundary = 1'b0;
        if (!enable) begin
            st_nx  = ST_OFF;
            cnt_nx = '0;
        end else begin
            unique case (st_q)
                ST_OFF: st_nx = ST_ARMED;
                ST_ARMED: begin
                    if (!group_sync || sync_start) begin
                        st_nx    = ST_UP;
                        cnt_nx   = '0;
                        boundary = 1'b1;
                    end
                end
                ST_UP: begin
                    if (tick) begin
                        if (center_mode) begin
                            cnt_nx = cnt_inc[CW-1:0];
                            if (cnt_inc >= {1'b0, prd_act}) st_nx = ST_DOWN;
                        end else if (cnt_inc >= {1'b0, prd_act}) begin
                            cnt_nx   = '0;
                            boundary = 1'b1;
                        end else begin
                            cnt_nx = cnt_inc[CW-1:0];
                        end
                    end
                end
                ST_DOWN: begin
                    if (tick) begin
                        if (cnt <= CW'(1)) begin
                            cnt_nx   = '0;
                            st_nx    = ST_UP;
                            boundary = 1'b1;
                        end else begin
                            cnt_nx = cnt - 1'b1;
                        end
                    end
                end
                default: st_nx = ST_OFF;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= ST_OFF;
        end else begin
            st_q <= st_nx;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt      <= '0;
            prd_sh   <= '0;
            duty_sh  <= '0;
            prd_act  <= '0;
            duty_act <= '0;
        end else begin
            cnt <= cnt_nx;
            if (boundary) begin
                prd_act  <= prd_sh;
                duty_act <= duty_sh;
            end
            if (prd_wr)  prd_sh  <= prd_data;
            if (duty_wr) duty_sh <= duty_data;
        end
    end

    always_comb begin
        running = (st_q == ST_UP) || (st_q == ST_DOWN);
        active  = (duty_act != '0) && ((duty_act >= prd_act) || (cnt < duty_act));
    end

    AST_CNT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (cnt == '0)); // R12
    AST_ARMED_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_ARMED && group_sync && !sync_start) |=> (st_q != ST_UP)); // R11
    AST_EDGE_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_UP && prd_act != '0) |-> (cnt < prd_act)); // R3
endmodule

// File: rtl/pwm_event.sv
module pwm_event
    import pwm_pkg::*;
#(
    parameter int TW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          running,
    input  logic          pin,
    input  logic [1:0]    edge_sel,
    input  logic          irq_en,
    input  logic          dma_en,
    input  logic          trig_en,
    input  logic [TW-1:0] trig_width,
    input  logic          eoi,
    output logic          irq,
    output logic          dma_req,
    output logic          trig_out
);
    logic          pin_q;
    logic          evt;
    logic [TW-1:0] trg_cnt;

    assign evt = running && (pin != pin_q) &&
                 ((pin && edge_sel[SEL_RISE]) || (!pin && edge_sel[SEL_FALL]));
    assign trig_out = (trg_cnt != '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pin_q   <= 1'b0;
            irq     <= 1'b0;
            dma_req <= 1'b0;
            trg_cnt <= '0;
        end else begin
            pin_q   <= pin;
            dma_req <= evt && dma_en;
            if (evt && irq_en)  irq <= 1'b1;
            else if (eoi)       irq <= 1'b0;
            if (evt && trig_en) trg_cnt <= (trig_width == '0) ? TW'(1) : trig_width;
            else if (trig_out)  trg_cnt <= trg_cnt - 1'b1;
        end
    end

    AST_IRQ_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !eoi) |=> irq); // R8
    AST_TRIG_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(trig_out) |-> $past(trig_en)); // R10
    AST_DMA_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dma_req) |-> $past(dma_en && running)); // R9
endmodule

// File: rtl/pwm_channel.sv
module pwm_channel #(
    parameter int CW = 16,
    parameter int DW = 8,
    parameter int TW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          enable,
    input  logic          group_sync,
    input  logic          sync_start,
    input  logic          center_mode,
    input  logic          pol_high,
    input  logic [1:0]    edge_sel,
    input  logic          irq_en,
    input  logic          dma_en,
    input  logic          trig_en,
    input  logic [TW-1:0] trig_width,
    input  logic [DW-1:0] clk_div,
    input  logic          prd_wr,
    input  logic [CW-1:0] prd_data,
    input  logic          duty_wr,
    input  logic [CW-1:0] duty_data,
    input  logic          eoi,
    output logic          pwm_out,
    output logic [CW-1:0] cnt_value,
    output logic          irq,
    output logic          dma_req,
    output logic          trig_out
);
    logic tick, running, active;

    pwm_prescaler #(.DW(DW)) u_presc (
        .clk(clk), .rst_n(rst_n), .run(running), .clk_div(clk_div), .tick(tick)
    );

    pwm_core #(.CW(CW)) u_core (
        .clk(clk), .rst_n(rst_n), .enable(enable), .group_sync(group_sync),
        .sync_start(sync_start), .center_mode(center_mode), .tick(tick),
        .prd_wr(prd_wr), .prd_data(prd_data), .duty_wr(duty_wr),
        .duty_data(duty_data), .cnt(cnt_value), .running(running), .active(active)
    );

    always_comb begin
        if (running) pwm_out = pol_high ? active : !active;
        else         pwm_out = !pol_high;
    end

    pwm_event #(.TW(TW)) u_evt (
        .clk(clk), .rst_n(rst_n), .running(running), .pin(pwm_out),
        .edge_sel(edge_sel), .irq_en(irq_en), .dma_en(dma_en), .trig_en(trig_en),
        .trig_width(trig_width), .eoi(eoi), .irq(irq), .dma_req(dma_req),
        .trig_out(trig_out)
    );

    AST_IDLE_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (pwm_out == !pol_high)); // R12
endmodule

// File: tb/pwm_channel_test.sv
module pwm_channel_test;
    localparam int CW = 16, DW = 8, TW = 8;

    logic clk = 1'b0, rst_n = 1'b0;
    logic enable = 0, group_sync = 0, sync_start = 0, center_mode = 0, pol_high = 1;
    logic [1:0] edge_sel = 2'b11;
    logic irq_en = 1, dma_en = 1, trig_en = 1;
    logic [TW-1:0] trig_width = 8'd2;
    logic [DW-1:0] clk_div = '0;
    logic prd_wr = 0, duty_wr = 0, eoi = 0;
    logic [CW-1:0] prd_data = '0, duty_data = '0;
    logic pwm_out, irq, dma_req, trig_out;
    logic [CW-1:0] cnt_value;

    int checks = 0, failures = 0, cycles = 0;
    string cur_req = "R1";

    always #2 clk = ~clk;

    pwm_channel #(.CW(CW), .DW(DW), .TW(TW)) uut (
        .clk(clk), .rst_n(rst_n), .enable(enable), .group_sync(group_sync),
        .sync_start(sync_start), .center_mode(center_mode), .pol_high(pol_high),
        .edge_sel(edge_sel), .irq_en(irq_en), .dma_en(dma_en), .trig_en(trig_en),
        .trig_width(trig_width), .clk_div(clk_div), .prd_wr(prd_wr),
        .prd_data(prd_data), .duty_wr(duty_wr), .duty_data(duty_data), .eoi(eoi),
        .pwm_out(pwm_out), .cnt_value(cnt_value), .irq(irq), .dma_req(dma_req),
        .trig_out(trig_out)
    );

    // Behavioural reference: 0 off, 1 armed, 2 up, 3 down
    int m_st = 0, m_cnt = 0, m_div = 0, m_prd = 0, m_duty = 0, m_sp = 0, m_sd = 0;
    int m_pinq = 0, m_irq = 0, m_dma = 0, m_trg = 0;

    function automatic int model_pin();
        int act;
        bit run;
        run = (m_st == 2) || (m_st == 3);
        act = (m_duty != 0) && ((m_duty >= m_prd) || (m_cnt < m_duty));
        if (!run) return pol_high ? 0 : 1;
        return pol_high ? act : (act ? 0 : 1);
    endfunction

    always @(posedge clk) begin
        cycles++;
        if (!rst_n) begin
            m_st = 0; m_cnt = 0; m_div = 0; m_prd = 0; m_duty = 0;
            m_sp = 0; m_sd = 0; m_pinq = 0; m_irq = 0; m_dma = 0; m_trg = 0;
        end else begin
            int pin, evt, tick;
            bit run;
            run = (m_st == 2) || (m_st == 3);
            pin = model_pin();
            evt = run && (pin != m_pinq) &&
                  ((pin == 1 && edge_sel[0]) || (pin == 0 && edge_sel[1]));
            if (evt && irq_en) m_irq = 1;
            else if (eoi)      m_irq = 0;
            m_dma = evt && dma_en;
            if (evt && trig_en) m_trg = (trig_width == 0) ? 1 : int'(trig_width);
            else if (m_trg > 0) m_trg--;
            m_pinq = pin;
            if (!enable) begin
                m_st = 0; m_cnt = 0; m_div = 0;
            end else if (m_st == 0) begin
                m_st = 1;
            end else if (m_st == 1) begin
                if (!group_sync || sync_start) begin
                    m_st = 2; m_cnt = 0; m_div = 0; m_prd = m_sp; m_duty = m_sd;
                end
            end else begin
                tick = (m_div == int'(clk_div));
                m_div = tick ? 0 : m_div + 1;
                if (tick) begin
                    if (m_st == 2) begin
                        if (center_mode) begin
                            m_cnt++;
                            if (m_cnt >= m_prd) m_st = 3;
                        end else if (m_cnt + 1 >= m_prd) begin
                            m_cnt = 0; m_prd = m_sp; m_duty = m_sd;
                        end else m_cnt++;
                    end else begin
                        if (m_cnt <= 1) begin
                            m_cnt = 0; m_st = 2; m_prd = m_sp; m_duty = m_sd;
                        end else m_cnt--;
                    end
                end
            end
            if (prd_wr)  m_sp = int'(prd_data);
            if (duty_wr) m_sd = int'(duty_data);
        end
    end

    task automatic check_eq(string req, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d at cycle %0d", req, what, act, exp, cycles);
        end
    endtask

    task automatic compare_all();
        check_eq(cur_req, "pwm_out", int'(pwm_out), model_pin());
        check_eq(cur_req, "cnt_value", int'(cnt_value), m_cnt);
        check_eq(cur_req, "irq", int'(irq), m_irq);
        check_eq(cur_req, "dma_req", int'(dma_req), m_dma);
        check_eq(cur_req, "trig_out", int'(trig_out), (m_trg > 0) ? 1 : 0);
    endtask

    task automatic step(int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            compare_all();
        end
    endtask

    task automatic write_prd(int v);
        prd_data = CW'(v); prd_wr = 1; step(1); prd_wr = 0;
    endtask

    task automatic write_duty(int v);
        duty_data = CW'(v); duty_wr = 1; step(1); duty_wr = 0;
    endtask

    initial begin
        cur_req = "R1";
        step(3);
        check_eq("R1", "reset cnt", int'(cnt_value), 0);
        check_eq("R1", "reset pin idle", int'(pwm_out), 0);
        rst_n = 1;
        step(2);
        write_prd(8);
        write_duty(3);
        cur_req = "R3";
        enable = 1;
        step(40);
        cur_req = "R2";
        clk_div = 8'd2;
        step(60);
        cur_req = "R7";
        clk_div = 8'd0;
        write_duty(6);
        step(3);
        write_prd(10);
        step(40);
        cur_req = "R4";
        center_mode = 1;
        write_prd(6);
        write_duty(2);
        step(60);
        cur_req = "R5";
        write_duty(0);
        step(40);
        write_duty(20);
        step(40);
        cur_req = "R6";
        write_duty(3);
        pol_high = 0;
        step(40);
        cur_req = "R8";
        pol_high = 1;
        center_mode = 0;
        edge_sel = 2'b01;
        eoi = 1;
        step(30);
        eoi = 0;
        step(10);
        eoi = 1; step(1); eoi = 0;
        edge_sel = 2'b10;
        step(20);
        eoi = 1; step(1); eoi = 0;
        edge_sel = 2'b00;
        step(20);
        check_eq("R8", "no edges selected keeps irq low", int'(irq), 0);
        cur_req = "R9";
        edge_sel = 2'b11;
        dma_en = 0;
        step(20);
        dma_en = 1; irq_en = 0;
        eoi = 1; step(1); eoi = 0;
        step(20);
        cur_req = "R10";
        irq_en = 1;
        trig_width = 8'd0;
        step(20);
        trig_width = 8'd5;
        step(40);
        trig_en = 0;
        step(20);
        cur_req = "R12";
        enable = 0;
        step(1);
        check_eq("R12", "disabled cnt", int'(cnt_value), 0);
        check_eq("R12", "disabled pin idle", int'(pwm_out), 0);
        step(10);
        cur_req = "R11";
        group_sync = 1;
        enable = 1;
        step(20);
        check_eq("R11", "armed cnt held", int'(cnt_value), 0);
        sync_start = 1; step(1); sync_start = 0;
        step(40);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #400000;
        failures++;
        $display("FAIL watchdog actual=%0d expected=%0d", cycles, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule